// File: doc/BRIEF.md
# Strapped-Address Management Register Bridge

This block is the device-side responder of a management bus. A host reaches the block's internal register space through a parallel access port that carries a 5-bit bus address, a 5-bit register number, a write strobe and a 16-bit write word. The read word is always driven. A 5-bit address strap picks one of two modes. With the strap at zero, the block decodes every bus address. Each (bus address, register) pair then selects one word of a 32 x 32 internal register file, which the host reads and writes directly.

With a non-zero strap, the block answers only at the strapped bus address, and only through two registers there. Register 0 is a command word and register 1 is a data word. A command that has its top bit set starts an internal access. Bits 9:5 name the target bank and bits 4:0 name the target register inside that bank. While the access runs, the top bit of register 0 reads back as a busy flag. Hosts poll this flag (typically up to 16 times) before they treat the access as timed out. A read command places the target word in the data register. A write command copies the data register into the target word. The busy flag clears on the same edge that completes the access.

Top module: `mgmt_bridge`

## Requirements
- R1: With the strap at zero, a write to (busAddr, regAddr) stores wrData in the register-file word selected by that pair, and no other word changes.
- R2: With the strap at zero, rdData shows the addressed register-file word in the same cycle. Reset clears the file.
- R3: With a non-zero strap, rdData is 0xFFFF for any other bus address, and writes to other bus addresses change no state.
- R4: At the strapped bus address, registers 2 to 31 read 0xFFFF and ignore writes.
- R5: A write to register 0 with bit 15 set, made while idle, is accepted, and register 0 bit 15 reads 1 from the next cycle. A write to register 0 with bit 15 clear is ignored.
- R6: After an accepted command, the busy flag reads 1 for exactly ACCESS_CYCLES cycles (ACCESS_CYCLES >= 1) and then reads 0.
- R7: Command bits 14:10 = 00110 (word base 0x9800) read file word [bits 9:5][bits 4:0] into the data register. The result appears on the edge that clears busy.
- R8: Command bits 14:10 = 00101 (word base 0x9400) write the data register value into file word [bits 9:5][bits 4:0] on the edge that clears busy.
- R9: Writes to register 0 or register 1 made while busy reads 1 are ignored. This includes the cycle in which busy clears.
- R10: Any other opcode with bit 15 set is busy for the same time and then leaves the file and the data register unchanged.
- R11: After reset, register 0 and register 1 read 0 and busy is 0.
- R12: Register 0 bits 14:0 read back the last accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| strapAddr | input | 5 | Address strap; zero selects the direct-mapped mode |
| busAddr | input | 5 | Bus (device) address of the access |
| regAddr | input | 5 | Register number of the access |
| wrEn | input | 1 | Write strobe for the addressed register |
| wrData | input | 16 | Write word |
| rdData | output | 16 | Read word of the addressed register |

## Verification
Two events can fall on the same edge: the completion of an internal access and a fresh host write to the command or data register. The bench schedules host writes at every point of a running access, including the exact edge on which busy clears. It then compares the read port on every cycle with a behavioural model that decides acceptance from the busy state before the edge. A dropped command, or a data word overwritten during a running read, shows up either in register 0's echo or in a later indirect read-back of the target word.

// File: rtl/mgmt_bridge_pkg.sv
package mgmt_bridge_pkg;

  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 16;
  localparam int OP_W     = 5;
  localparam int FILE_IDX_W = 2 * ADDR_W;
  localparam int FILE_DEPTH = 1 << FILE_IDX_W;

  // Opcode field sits in command bits 14:10
  localparam logic [OP_W-1:0] OP_READ  = 5'b00110;
  localparam logic [OP_W-1:0] OP_WRITE = 5'b00101;

  localparam logic [ADDR_W-1:0] REG_CMD  = 5'd0;
  localparam logic [ADDR_W-1:0] REG_DATA = 5'd1;

  localparam logic [DATA_W-1:0] NO_RESPONSE = 16'hFFFF;

  typedef struct packed {
    logic cmdLoad;
    logic dataLoad;
    logic fileRead;
    logic fileWrite;
    logic directWrite;
  } strobe_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } ctrl_state_t;

endpackage

// File: rtl/mgmt_bridge_ctrl.sv
module mgmt_bridge_ctrl
  import mgmt_bridge_pkg::*;
#(
  parameter int ACCESS_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] strapAddr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic              wrStart,
  input  logic [OP_W-1:0]   cmdOp,
  output strobe_t           strb,
  output logic              busy
);

  localparam int CNT_W = (ACCESS_CYCLES > 1) ? $clog2(ACCESS_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACCESS_CYCLES - 1);

  ctrl_state_t stateQ;
  logic [CNT_W-1:0] cntQ;

  logic directMode;
  logic addrHit;
  logic hostWrite;
  logic accept;
  logic finish;

  assign directMode = (strapAddr == '0);
  assign addrHit    = !directMode && (busAddr == strapAddr);
  assign hostWrite  = addrHit && wrEn && (stateQ == ST_IDLE);
  assign accept     = hostWrite && (regAddr == REG_CMD) && wrStart;
  assign finish     = (stateQ == ST_BUSY) && (cntQ == '0);
  assign busy       = (stateQ == ST_BUSY);

  always_comb begin
    strb             = '0;
    strb.cmdLoad     = accept;
    strb.dataLoad    = hostWrite && (regAddr == REG_DATA);
    strb.fileRead    = finish && (cmdOp == OP_READ);
    strb.fileWrite   = finish && (cmdOp == OP_WRITE);
    strb.directWrite = directMode && wrEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (accept) begin
            stateQ <= ST_BUSY;
            cntQ   <= CNT_LOAD;
          end
        end
        ST_BUSY: begin
          if (finish) begin
            stateQ <= ST_IDLE;
          end else begin
            cntQ <= cntQ - 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  // R5: an accepted start raises busy on the following edge
  assert_start_sets_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> busy);

  // R6: busy drops right after the final counted cycle
  assert_busy_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    finish |=> !busy);

  // R6: busy is held while cycles remain
  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cntQ != '0) |=> busy);

  // R9: no command is taken while an access is in flight
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.cmdLoad && !strb.dataLoad);

  // R7/R8: file access strobes only fire at completion of a running access
  assert_file_strobe_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fileRead || strb.fileWrite) |-> busy);

endmodule

// File: rtl/mgmt_bridge_dp.sv
module mgmt_bridge_dp
  import mgmt_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] strapAddr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  strobe_t           strb,
  input  logic              busy,
  output logic [OP_W-1:0]   cmdOp,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] mem [FILE_DEPTH];
  logic [DATA_W-2:0] cmdQ;
  logic [DATA_W-1:0] dataQ;

  logic [FILE_IDX_W-1:0] fileIdx;
  logic [FILE_IDX_W-1:0] portIdx;
  logic [FILE_IDX_W-1:0] wrIdx;
  logic [DATA_W-1:0]     wrWord;
  logic                  wrFile;
  logic [DATA_W-1:0]     fileWord;
  logic                  directMode;

  assign directMode = (strapAddr == '0);
  assign cmdOp      = cmdQ[DATA_W-2 -: OP_W];
  assign fileIdx    = cmdQ[FILE_IDX_W-1:0];
  assign portIdx    = {busAddr, regAddr};
  assign fileWord   = mem[fileIdx];

  assign wrFile = strb.directWrite || strb.fileWrite;
  assign wrIdx  = strb.directWrite ? portIdx : fileIdx;
  assign wrWord = strb.directWrite ? wrData : dataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < FILE_DEPTH; i++) begin
        mem[i] <= '0;
      end
    end else if (wrFile) begin
      mem[wrIdx] <= wrWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ  <= '0;
      dataQ <= '0;
    end else begin
      if (strb.cmdLoad) begin
        cmdQ <= wrData[DATA_W-2:0];
      end
      if (strb.fileRead) begin
        dataQ <= fileWord;
      end else if (strb.dataLoad) begin
        dataQ <= wrData;
      end
    end
  end

  always_comb begin
    if (directMode) begin
      rdData = mem[portIdx];
    end else if (busAddr != strapAddr) begin
      rdData = NO_RESPONSE;
    end else if (regAddr == REG_CMD) begin
      rdData = {busy, cmdQ};
    end else if (regAddr == REG_DATA) begin
      rdData = dataQ;
    end else begin
      rdData = NO_RESPONSE;
    end
  end

  // R9: the data word only moves by a read completion while busy
  assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.fileRead) |=> $stable(dataQ));

  // R9: the command word stays put for the whole access
  assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(cmdQ));

  // R8: a write completion lands the data word in the target entry
  assert_file_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.fileWrite |=> mem[$past(fileIdx)] == $past(dataQ));

  // R7: a read completion captures the target entry
  assert_read_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.fileRead |=> dataQ == $past(fileWord));

endmodule

// File: rtl/mgmt_bridge.sv
module mgmt_bridge
  import mgmt_bridge_pkg::*;
#(
  parameter int ACCESS_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [4:0]  strapAddr,
  input  logic [4:0]  busAddr,
  input  logic [4:0]  regAddr,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  output logic [15:0] rdData
);

  strobe_t         strb;
  logic            busy;
  logic [OP_W-1:0] cmdOp;

  mgmt_bridge_ctrl #(
    .ACCESS_CYCLES(ACCESS_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .strapAddr(strapAddr),
    .busAddr  (busAddr),
    .regAddr  (regAddr),
    .wrEn     (wrEn),
    .wrStart  (wrData[DATA_W-1]),
    .cmdOp    (cmdOp),
    .strb     (strb),
    .busy     (busy)
  );

  mgmt_bridge_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strapAddr(strapAddr),
    .busAddr  (busAddr),
    .regAddr  (regAddr),
    .wrData   (wrData),
    .strb     (strb),
    .busy     (busy),
    .cmdOp    (cmdOp),
    .rdData   (rdData)
  );

  // R11: out of reset nothing is in flight
  assert_reset_idle_R11: assert property (@(posedge clk)
    !rstN |=> !busy);

endmodule

// File: tb/sim_mgmt_bridge.sv
module sim_mgmt_bridge;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  strapAddr = '0;
  logic [4:0]  busAddr = '0;
  logic [4:0]  regAddr = '0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [15:0] mMem [0:1023];
  logic [14:0] mCmd;
  logic [15:0] mData;
  bit          mBusy;
  int          mLeft;

  always #(CLK_PERIOD/2) clk = ~clk;

  mgmt_bridge #(.ACCESS_CYCLES(LAT)) u0 (
    .clk(clk), .rstN(rstN), .strapAddr(strapAddr), .busAddr(busAddr),
    .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData), .rdData(rdData)
  );

  function automatic logic [15:0] mRead(input logic [4:0] b, input logic [4:0] r);
    if (strapAddr == 0) return mMem[{b, r}];
    if (b != strapAddr) return 16'hFFFF;
    if (r == 0) return {mBusy, mCmd};
    if (r == 1) return mData;
    return 16'hFFFF;
  endfunction

  task automatic mReset();
    for (int i = 0; i < 1024; i++) mMem[i] = '0;
    mCmd = '0; mData = '0; mBusy = 0; mLeft = 0;
  endtask

  // one edge of the model, using pre-edge state for every decision
  task automatic mEdge(input logic [4:0] b, input logic [4:0] r,
                       input bit wr, input logic [15:0] wd);
    bit wasBusy = mBusy;
    if (strapAddr == 0) begin
      if (wr) mMem[{b, r}] = wd;
    end else begin
      if (wasBusy) begin
        if (mLeft == 0) begin
          if (mCmd[14:10] == 5'b00110) mData = mMem[mCmd[9:0]];
          else if (mCmd[14:10] == 5'b00101) mMem[mCmd[9:0]] = mData;
          mBusy = 0;
        end else begin
          mLeft--;
        end
      end else if (wr && b == strapAddr) begin
        if (r == 0 && wd[15]) begin
          mCmd = wd[14:0]; mBusy = 1; mLeft = LAT - 1;
        end else if (r == 1) begin
          mData = wd;
        end
      end
    end
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s bus=%0d reg=%0d actual=%h expected=%h", tag, busAddr, regAddr, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] b, input logic [4:0] r, input bit wr,
                      input logic [15:0] wd, input string tag);
    @(negedge clk);
    busAddr = b; regAddr = r; wrEn = wr; wrData = wd;
    #1 check(tag, rdData, mRead(b, r));
    @(posedge clk);
    mEdge(b, r, wr, wd);
  endtask

  task automatic doReset(input logic [4:0] strap);
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; strapAddr = strap;
    repeat (2) @(posedge clk);
    mReset();
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic poll(input string tag);
    for (int i = 0; i < 16; i++) begin
      step(strapAddr, 5'd0, 1'b0, 16'h0, tag);
      if (!mBusy) break;
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    // ---------- direct-mapped mode ----------
    doReset(5'd0);
    step(5'd0, 5'd0, 0, 16'h0, "R11");
    step(5'd31, 5'd31, 0, 16'h0, "R2");
    step(5'd0, 5'd0, 1, 16'h1234, "R1");
    step(5'd31, 5'd31, 1, 16'hABCD, "R1");
    step(5'd5, 5'd17, 1, 16'h5A5A, "R1");
    step(5'd0, 5'd0, 0, 16'h0, "R2");
    step(5'd31, 5'd31, 0, 16'h0, "R2");
    step(5'd5, 5'd17, 0, 16'h0, "R2");
    step(5'd5, 5'd16, 0, 16'h0, "R1");

    // ---------- strapped (indirect) mode ----------
    doReset(5'd4);
    step(5'd4, 5'd0, 0, 16'h0, "R11");
    step(5'd4, 5'd1, 0, 16'h0, "R11");
    step(5'd7, 5'd3, 1, 16'h1111, "R3");
    step(5'd7, 5'd3, 0, 16'h0, "R3");
    step(5'd4, 5'd9, 1, 16'h2222, "R4");
    step(5'd4, 5'd9, 0, 16'h0, "R4");
    step(5'd4, 5'd1, 0, 16'h0, "R3");

    // indirect write then read back
    step(5'd4, 5'd1, 1, 16'hBEEF, "R8");
    step(5'd4, 5'd0, 1, 16'h9400 | (16'd3 << 5) | 16'd12, "R8");
    poll("R6");
    step(5'd4, 5'd0, 1, 16'h9800 | (16'd3 << 5) | 16'd12, "R7");
    poll("R6");
    step(5'd4, 5'd1, 0, 16'h0, "R7");
    step(5'd4, 5'd0, 0, 16'h0, "R12");

    // foreign-address and unused-register writes left the file untouched
    step(5'd4, 5'd0, 1, 16'h9800 | (16'd7 << 5) | 16'd3, "R3");
    poll("R6");
    step(5'd4, 5'd1, 0, 16'h0, "R3");
    step(5'd4, 5'd0, 1, 16'h9800 | (16'd4 << 5) | 16'd9, "R4");
    poll("R6");
    step(5'd4, 5'd1, 0, 16'h0, "R4");

    // writes during a running access, including its completion edge
    step(5'd4, 5'd1, 1, 16'h0F0F, "R8");
    step(5'd4, 5'd0, 1, 16'h9400 | (16'd1 << 5) | 16'd1, "R8");
    step(5'd4, 5'd1, 1, 16'hFFFF, "R9");
    step(5'd4, 5'd0, 1, 16'h9800 | (16'd2 << 5) | 16'd2, "R9");
    step(5'd4, 5'd0, 1, 16'h9800 | (16'd6 << 5) | 16'd6, "R9");
    step(5'd4, 5'd0, 0, 16'h0, "R9");
    step(5'd4, 5'd1, 0, 16'h0, "R9");
    step(5'd4, 5'd0, 1, 16'h9800 | (16'd1 << 5) | 16'd1, "R8");
    poll("R6");
    step(5'd4, 5'd1, 0, 16'h0, "R8");

    // start bit clear: command ignored
    step(5'd4, 5'd0, 1, 16'h1800 | (16'd3 << 5) | 16'd12, "R5");
    step(5'd4, 5'd0, 0, 16'h0, "R5");

    // unknown opcodes: busy, then nothing changes
    step(5'd4, 5'd1, 1, 16'h7777, "R10");
    step(5'd4, 5'd0, 1, 16'h8000 | (16'd1 << 5) | 16'd1, "R10");
    poll("R6");
    step(5'd4, 5'd1, 0, 16'h0, "R10");
    step(5'd4, 5'd0, 1, 16'hFC00 | (16'd3 << 5) | 16'd12, "R10");
    poll("R6");
    step(5'd4, 5'd1, 0, 16'h0, "R10");
    step(5'd4, 5'd0, 1, 16'h9800 | (16'd1 << 5) | 16'd1, "R10");
    poll("R6");
    step(5'd4, 5'd1, 0, 16'h0, "R10");
    step(5'd4, 5'd0, 0, 16'h0, "R12");

    done = 1'b1;
    finishRun();
  end

endmodule